// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a four-beat burst to a synchronous memory. On a load cycle it captures the address from its input bus. On each continuation cycle that follows, it steps only the two lowest address bits and holds every upper bit as loaded. The order of the low bits comes from a mode input: interleaved (the start bits XORed with the beat number) or linear (the start bits plus the beat number, wrapping within the group of four).

A single control line separates the two kinds of cycle. When `advance` is low on a clock edge, a new access starts. The chip-select and write/read command inputs are captured on that edge and held for the rest of the burst. When `advance` is high, the burst continues. On those cycles the address bus and both command inputs are ignored.

The outputs are the full beat address, a continuation flag, and the latched command. Memory array, data path, output enables and byte masks belong to the surrounding logic.

Top module: `burst_addr_seq`

## Requirements
- R1: When `advance` is low at a rising edge, `addrOut` equals the `addrIn` sampled at that edge from the next cycle on, and `burstCont` is 0.
- R2: When `advance` is high at a rising edge, `burstCont` is 1 in the following cycle and the low two bits of `addrOut` move to the next position of the selected order.
- R3: During continuation cycles, bits above the low two of `addrOut` keep their loaded value whatever `addrIn` carries.
- R4: With `orderSel` = 1 (interleaved), beat k (k = 0..3, k = 0 being the loaded beat) carries low bits equal to start XOR k. This gives 00,01,10,11 / 01,00,11,10 / 10,11,00,01 / 11,10,01,00.
- R5: With `orderSel` = 0 (linear), beat k carries low bits equal to (start + k) mod 4. This gives 00,01,10,11 / 01,10,11,00 / 10,11,00,01 / 11,00,01,10.
- R6: A continuation after the fourth beat returns the low bits to the start value, and the upper bits stay unchanged.
- R7: `opSel` and `opWrite` take `selEn` and `wrEn` at a load edge and keep those values through continuation cycles whatever `selEn` and `wrEn` then carry.
- R8: A synchronous active-high `rst` clears `addrOut`, `burstCont`, `opSel` and `opWrite` to 0 in the cycle after the reset edge, and takes priority over `advance`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | 0 = load a new address, 1 = continue the burst |
| addrIn | input | ADDR_W | External address, used on load cycles |
| selEn | input | 1 | Chip select, captured on load cycles |
| wrEn | input | 1 | 1 = write, 0 = read, captured on load cycles |
| orderSel | input | 1 | 1 = interleaved order, 0 = linear order (board should pull high) |
| addrOut | output | ADDR_W | Address of the current beat |
| burstCont | output | 1 | 1 when the current beat is a continuation |
| opSel | output | 1 | Chip select latched at the last load |
| opWrite | output | 1 | Write flag latched at the last load |

## Verification
The order checks assume that `orderSel` is a static strap that does not change during a burst. They also assume `advance`, `selEn` and `wrEn` are always driven to known levels. The stimulus sets `orderSel` only before a load cycle. It changes the other inputs only on the falling edge, and it never leaves them unknown after reset. Since `orderSel` is applied combinationally, a mid-burst change would move the address on purpose, and that case lies outside what the checks model.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic loadNew;   // capture address and command
    logic stepBeat;  // advance within the current burst
  } seqStrobe_t;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burstOrder_e;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  output seqStrobe_t        strobes,
  output logic [BEAT_W-1:0] beatCnt,
  output logic              burstCont
);

  always_comb begin
    strobes.loadNew  = !advance;
    strobes.stepBeat = advance;
  end

  // The beat counter wraps naturally, so a fifth beat revisits the start
  always_ff @(posedge clk) begin
    if (rst) begin
      beatCnt   <= '0;
      burstCont <= 1'b0;
    end else if (strobes.loadNew) begin
      beatCnt   <= '0;
      burstCont <= 1'b0;
    end else begin
      beatCnt   <= beatCnt + 1'b1;
      burstCont <= 1'b1;
    end
  end

endmodule

// File: rtl/burst_order.sv
module burst_order
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] startLow,
  input  logic [BEAT_W-1:0] beat,
  input  logic              orderSel,
  output logic [BEAT_W-1:0] seqLow
);

  logic [BEAT_W-1:0] xorLow;
  logic [BEAT_W-1:0] sumLow;

  genvar gi;
  generate
    for (gi = 0; gi < BEAT_W; gi++) begin : g_xor
      assign xorLow[gi] = startLow[gi] ^ beat[gi];
    end
  endgenerate

  assign sumLow = startLow + beat;

  always_comb begin
    if (burstOrder_e'(orderSel) == ORDER_INTERLEAVE) seqLow = xorLow;
    else                                             seqLow = sumLow;
  end

endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobes,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              selEn,
  input  logic              wrEn,
  input  logic [BEAT_W-1:0] beatCnt,
  input  logic              orderSel,
  output logic [ADDR_W-1:0] addrOut,
  output logic              opSel,
  output logic              opWrite
);

  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [UPPER_W-1:0] baseUpper;
  logic [BEAT_W-1:0]  baseLow;
  logic [BEAT_W-1:0]  curLow;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseUpper <= '0;
      baseLow   <= '0;
      opSel     <= 1'b0;
      opWrite   <= 1'b0;
    end else if (strobes.loadNew) begin
      baseUpper <= addrIn[ADDR_W-1:BEAT_W];
      baseLow   <= addrIn[BEAT_W-1:0];
      opSel     <= selEn;
      opWrite   <= wrEn;
    end
  end

  burst_order #(.BEAT_W(BEAT_W)) i_order (
    .startLow (baseLow),
    .beat     (beatCnt),
    .orderSel (orderSel),
    .seqLow   (curLow)
  );

  assign addrOut = {baseUpper, curLow};

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              selEn,
  input  logic              wrEn,
  input  logic              orderSel,
  output logic [ADDR_W-1:0] addrOut,
  output logic              burstCont,
  output logic              opSel,
  output logic              opWrite
);

  localparam int BEAT_W = 2;

  seqStrobe_t        strobes;
  logic [BEAT_W-1:0] beatCnt;

  burst_ctrl #(.BEAT_W(BEAT_W)) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .advance   (advance),
    .strobes   (strobes),
    .beatCnt   (beatCnt),
    .burstCont (burstCont)
  );

  burst_datapath #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) i_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .addrIn   (addrIn),
    .selEn    (selEn),
    .wrEn     (wrEn),
    .beatCnt  (beatCnt),
    .orderSel (orderSel),
    .addrOut  (addrOut),
    .opSel    (opSel),
    .opWrite  (opWrite)
  );

endmodule

// File: rtl/burst_addr_seq_checker.sv
module burst_addr_seq_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              advance,
  input logic [ADDR_W-1:0] addrIn,
  input logic              selEn,
  input logic              wrEn,
  input logic              orderSel,
  input logic [ADDR_W-1:0] addrOut,
  input logic              burstCont,
  input logic              opSel,
  input logic              opWrite
);

  // Independent port-level model of start bits and beat number
  logic [1:0] mStart;
  logic [1:0] mBeat;

  always_ff @(posedge clk) begin
    if (rst) begin
      mStart <= 2'b00;
      mBeat  <= 2'b00;
    end else if (!advance) begin
      mStart <= addrIn[1:0];
      mBeat  <= 2'b00;
    end else begin
      mBeat  <= mBeat + 2'd1;
    end
  end

  p_load_capture_r1: assert property (@(posedge clk) disable iff (rst)
    !advance |=> (addrOut == $past(addrIn)) && !burstCont);

  p_cont_flag_r2: assert property (@(posedge clk) disable iff (rst)
    advance |=> burstCont);

  p_upper_hold_r3: assert property (@(posedge clk) disable iff (rst)
    advance |=> addrOut[ADDR_W-1:2] == $past(addrOut[ADDR_W-1:2]));

  p_interleave_r4: assert property (@(posedge clk) disable iff (rst)
    (burstCont && orderSel) |-> addrOut[1:0] == (mStart ^ mBeat));

  p_linear_r5: assert property (@(posedge clk) disable iff (rst)
    (burstCont && !orderSel) |-> addrOut[1:0] == 2'(mStart + mBeat));

  p_wrap_start_r6: assert property (@(posedge clk) disable iff (rst)
    (burstCont && mBeat == 2'b00) |-> addrOut[1:0] == mStart);

  p_cmd_hold_r7: assert property (@(posedge clk) disable iff (rst)
    advance |=> $stable(opSel) && $stable(opWrite));

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (addrOut == '0) && !burstCont && !opSel && !opWrite);

endmodule

bind burst_addr_seq burst_addr_seq_checker #(.ADDR_W(ADDR_W)) i_checker (
  .clk       (clk),
  .rst       (rst),
  .advance   (advance),
  .addrIn    (addrIn),
  .selEn     (selEn),
  .wrEn      (wrEn),
  .orderSel  (orderSel),
  .addrOut   (addrOut),
  .burstCont (burstCont),
  .opSel     (opSel),
  .opWrite   (opWrite)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

  localparam int ADDR_W   = 20;
  localparam int CLK_PER  = 10;
  localparam int WDOG_CYC = 50000;

  logic              clk = 1'b0;
  logic              rst;
  logic              advance;
  logic [ADDR_W-1:0] addrIn;
  logic              selEn;
  logic              wrEn;
  logic              orderSel;
  logic [ADDR_W-1:0] addrOut;
  logic              burstCont;
  logic              opSel;
  logic              opWrite;

  int checks = 0;
  int errors = 0;

  always #(CLK_PER/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) i_burst_addr_seq (
    .clk       (clk),
    .rst       (rst),
    .advance   (advance),
    .addrIn    (addrIn),
    .selEn     (selEn),
    .wrEn      (wrEn),
    .orderSel  (orderSel),
    .addrOut   (addrOut),
    .burstCont (burstCont),
    .opSel     (opSel),
    .opWrite   (opWrite)
  );

  task automatic check(input string req, input logic [ADDR_W+2:0] act,
                       input logic [ADDR_W+2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock with the given controls applied at the falling edge
  task automatic cycle(input logic adv, input logic [ADDR_W-1:0] a,
                       input logic s, input logic w);
    @(negedge clk);
    advance = adv; addrIn = a; selEn = s; wrEn = w;
    @(posedge clk);
    #1;
  endtask

  task automatic test_reset_state();
    @(negedge clk);
    rst = 1'b1; advance = 1'b1; addrIn = '1; selEn = 1'b1; wrEn = 1'b1;
    @(posedge clk); #1;
    check("R8 reset state", {opSel, opWrite, burstCont, addrOut}, '0);
    @(negedge clk); rst = 1'b0;
  endtask

  // Load and run five continuation beats in the given order
  task automatic test_burst(input logic mode, input logic [ADDR_W-1:0] a);
    logic [1:0] st;
    logic [1:0] e;
    st = a[1:0];
    @(negedge clk); orderSel = mode;
    cycle(1'b0, a, 1'b1, mode);
    check("R1 load address", {1'b0, 1'b0, burstCont, addrOut}, {3'b000, a});
    for (int k = 1; k <= 5; k++) begin
      cycle(1'b1, ~a, 1'b0, ~mode);
      if (mode) e = st ^ 2'(k);
      else      e = st + 2'(k);
      check(mode ? "R4 interleaved beat" : "R5 linear beat",
            {2'b00, 1'b0, addrOut[1:0]}, {3'b000, 18'd0, e} );
      check("R2 continuation flag", {{ADDR_W+2{1'b0}}, burstCont}, 1);
      check("R3 upper bits held", {3'b000, addrOut[ADDR_W-1:2], 2'b00},
            {3'b000, a[ADDR_W-1:2], 2'b00});
      if (k == 4)
        check("R6 wrap to start", {1'b0, addrOut}, {1'b0, a});
    end
  endtask

  task automatic test_cmd_latch(input logic s, input logic w);
    cycle(1'b0, 20'h1A5C3, s, w);
    check("R7 command captured", {opSel, opWrite}, {s, w});
    for (int k = 0; k < 3; k++) begin
      cycle(1'b1, 20'h00000, ~s, ~w);
      check("R7 command held", {opSel, opWrite}, {s, w});
    end
  endtask

  task automatic test_back_to_back();
    orderSel = 1'b1;
    cycle(1'b0, 20'h3F002, 1'b1, 1'b0);
    cycle(1'b1, 20'h0, 1'b0, 1'b0);
    cycle(1'b0, 20'h12341, 1'b0, 1'b1);
    check("R1 reload mid burst", {burstCont, opSel, opWrite, addrOut},
          {3'b001, 20'h12341});
  endtask

  task automatic test_reset_mid_burst();
    orderSel = 1'b0;
    cycle(1'b0, 20'hABCDE, 1'b1, 1'b1);
    cycle(1'b1, 20'h0, 1'b1, 1'b1);
    @(negedge clk);
    rst = 1'b1; advance = 1'b1;
    @(posedge clk); #1;
    check("R8 reset beats advance", {opSel, opWrite, burstCont, addrOut}, '0);
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1; advance = 1'b0; addrIn = '0; selEn = 1'b0; wrEn = 1'b0;
    orderSel = 1'b1;
    repeat (2) @(posedge clk);
    test_reset_state();
    for (int s = 0; s < 4; s++) test_burst(1'b1, 20'h5A5A4 | 20'(s));
    for (int s = 0; s < 4; s++) test_burst(1'b0, 20'hC3F08 | 20'(s));
    test_burst(1'b1, 20'hFFFFF);
    test_burst(1'b0, 20'h00003);
    test_cmd_latch(1'b1, 1'b0);
    test_cmd_latch(1'b0, 1'b1);
    test_back_to_back();
    test_reset_mid_burst();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule